// File: doc/BRIEF.md
# Circular Trace Capture Buffer with Scan-Chain Register Access

The block stores one trace word on every clock in which capture is enabled and a valid word is presented. Each word goes into a circular RAM at a write pointer, and that pointer wraps modulo the RAM depth. A debugger reaches the block through an external TAP controller. The TAP supplies capture, shift and update strobes, the serial data in and out, and the current instruction code. All strobes are one-cycle enables in the block's clock domain.

A 40-bit scan frame reaches a small file of 32-bit registers. These registers give an identification word, the RAM geometry, a status word, the RAM contents, both pointers, a post-trigger countdown and a control word. Reads are pipelined. The scan that names a register latches its value, and the next scan shifts that value out. Reading RAM data moves the read pointer forward, so software can drain the buffer with a stream of scans.

A trigger input marks an event of interest. After the trigger, a programmed number of further words is stored and then capture freezes, so the trace around the event is kept.

Top module: `trace_vault`

## Requirements
- R1: The scan frame is 40 bits and shifts least significant bit first, from `tdi` towards `tdo`. Bits 31:0 are data, bits 38:32 are a register address, and bit 39 is 1 for a write and 0 for a read. The strobes act only while `ir_sel` equals 4'hC. With any other code the chain does not move and register state does not change.
- R2: When a read frame is updated, the addressed value is latched. The next capture loads that value into bits 31:0 and zeros into bits 39:32. After reset the latched value is 0.
- R3: The register addresses are 0 identification (the `ID_CODE` parameter), 1 RAM depth (2^`DEPTH_LOG2`), 2 RAM word width (`WORD_W`), 3 status, 4 RAM data, 5 read pointer, 6 write pointer, 7 trigger count and 8 control. Addresses 0 to 4 ignore writes. Any other address reads as 0.
- R4: A read of address 4 returns the RAM word at the read pointer, zero-extended. It then moves the read pointer up by one, modulo the depth, so two back-to-back selections skip one entry. A write to address 4 does not move the pointer.
- R5: A word is stored in a cycle where `trc_valid` is high and capture is active (status bit 0). It goes to the write pointer, which then moves up by one modulo the depth. Storing into the last slot sets status bit 1 (wrapped). After a wrap, the oldest entry is at the write pointer and the newest at the write pointer minus one.
- R6: Writes to addresses 5 and 6 load the read and write pointers from the low data bits. A write-pointer load clears the wrapped flag and cancels any store in the same cycle.
- R7: Control bit 0 enables capture and resets to 0. Status bit 0 is high when the enable is set and capture is not halted. While the enable is clear, no word is stored.
- R8: The first stored word with `trc_trigger` high sets status bit 2. After that word, each stored word decrements the trigger count. When the count reaches 0, capture halts (status bit 3) until address 7 is written, which reloads the count and clears the trigger flag. The count reads back as it decrements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capture and register access |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | Trace word valid this cycle |
| trc_word | input | WORD_W | Trace word |
| trc_trigger | input | 1 | Trigger event accompanying the trace word |
| ir_sel | input | 4 | Current TAP instruction code |
| cap_en | input | 1 | Capture-DR strobe |
| shift_en | input | 1 | Shift-DR strobe |
| upd_en | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |

## Verification
The checker assumes the TAP drives at most one of the capture, shift and update strobes in a cycle. It also assumes the instruction code stays stable for the whole length of a frame. The stimulus keeps to these rules by sending each frame as a fixed sequence: one capture cycle, forty shift cycles and one update cycle, with `ir_sel` changed only between frames. Trace words are sent only while no frame is in flight, so pointer loads and stores never meet in the bench, although the design defines what happens when they do.

// File: rtl/tv_pkg.sv
package tv_pkg;
   localparam int CHAIN_W = 40;
   localparam int REG_W   = 32;
   localparam int RADDR_W = 7;
   localparam int IR_W    = 4;
   localparam logic [IR_W-1:0] IR_REG_ACCESS = 4'hC;

   localparam logic [RADDR_W-1:0] RA_ID     = 7'd0;
   localparam logic [RADDR_W-1:0] RA_DEPTH  = 7'd1;
   localparam logic [RADDR_W-1:0] RA_WIDTH  = 7'd2;
   localparam logic [RADDR_W-1:0] RA_STATUS = 7'd3;
   localparam logic [RADDR_W-1:0] RA_DATA   = 7'd4;
   localparam logic [RADDR_W-1:0] RA_RDPTR  = 7'd5;
   localparam logic [RADDR_W-1:0] RA_WRPTR  = 7'd6;
   localparam logic [RADDR_W-1:0] RA_TCOUNT = 7'd7;
   localparam logic [RADDR_W-1:0] RA_CTRL   = 7'd8;

   typedef struct packed {
      logic               write;
      logic [RADDR_W-1:0] addr;
      logic [REG_W-1:0]   data;
   } frame_t;
endpackage

// File: rtl/tv_chain.sv
module tv_chain
   import tv_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             cap_en,
   input  logic             shift_en,
   input  logic             upd_en,
   input  logic             tdi,
   input  logic [REG_W-1:0] hold,
   output logic             tdo,
   output logic             upd_fire,
   output frame_t           upd_frame
);
   logic [CHAIN_W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr <= '0;
      else if (sel && cap_en)
         sr <= {{(CHAIN_W-REG_W){1'b0}}, hold};
      else if (sel && shift_en)
         sr <= {tdi, sr[CHAIN_W-1:1]};
   end

   assign tdo       = sr[0];
   assign upd_fire  = sel && upd_en;
   assign upd_frame = frame_t'(sr);
endmodule

// File: rtl/tv_ram.sv
module tv_ram #(
   parameter int AW = 6,
   parameter int WW = 20
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [WW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [WW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [WW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tv_capture.sv
module tv_capture #(
   parameter int AW  = 6,
   parameter int TCW = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trc_valid,
   input  logic           trc_trigger,
   input  logic           ld_ctrl,
   input  logic           ld_tcount,
   input  logic           ld_wrptr,
   input  logic [31:0]    ld_data,
   output logic           store,
   output logic [AW-1:0]  wr_ptr,
   output logic           ctl_en,
   output logic           active,
   output logic           wrapped,
   output logic           triggered,
   output logic           halted,
   output logic [TCW-1:0] tcount
);
   assign halted = triggered && (tcount == '0);
   assign active = ctl_en && !halted;
   assign store  = trc_valid && active && !ld_wrptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en <= 1'b0;
      end else if (ld_ctrl) begin
         ctl_en <= ld_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         wrapped <= 1'b0;
      end else if (ld_wrptr) begin
         wr_ptr  <= ld_data[AW-1:0];
         wrapped <= 1'b0;
      end else if (store) begin
         wr_ptr <= wr_ptr + 1'b1;
         if (&wr_ptr) wrapped <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcount    <= '0;
         triggered <= 1'b0;
      end else if (ld_tcount) begin
         tcount    <= ld_data[TCW-1:0];
         triggered <= 1'b0;
      end else if (store) begin
         if (triggered && (tcount != '0)) tcount <= tcount - 1'b1;
         if (trc_trigger && !triggered)    triggered <= 1'b1;
      end
   end
endmodule

// File: rtl/trace_vault.sv
module trace_vault
   import tv_pkg::*;
#(
   parameter int          DEPTH_LOG2 = 6,
   parameter int          WORD_W     = 20,
   parameter int          TCNT_W     = 16,
   parameter logic [31:0] ID_CODE    = 32'h5A7C_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trc_valid,
   input  logic [WORD_W-1:0] trc_word,
   input  logic              trc_trigger,
   input  logic [3:0]        ir_sel,
   input  logic              cap_en,
   input  logic              shift_en,
   input  logic              upd_en,
   input  logic              tdi,
   output logic              tdo
);
   localparam int AW    = DEPTH_LOG2;
   localparam int DEPTH = 1 << AW;

   if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 12) begin : g_bad_depth
      $error("trace_vault: DEPTH_LOG2 must lie in 1..12");
   end
   if (WORD_W < 1 || WORD_W > REG_W) begin : g_bad_width
      $error("trace_vault: WORD_W must lie in 1..32");
   end
   if (TCNT_W < 1 || TCNT_W > REG_W) begin : g_bad_tcnt
      $error("trace_vault: TCNT_W must lie in 1..32");
   end

   logic             sel;
   logic             upd_fire;
   frame_t           upd_frame;
   logic [REG_W-1:0] rd_hold;
   logic [REG_W-1:0] rd_value;
   logic             wr_hit, rd_hit;
   logic             ld_ctrl, ld_tcount, ld_wrptr, ld_rdptr, rd_data_hit;
   logic [AW-1:0]    rd_ptr;
   logic [AW-1:0]    wr_ptr;
   logic             store, ctl_en, active, wrapped, triggered, halted;
   logic [TCNT_W-1:0] tcount;
   logic [WORD_W-1:0] ram_q;
   logic [REG_W-1:0]  ram_ext;
   logic [REG_W-1:0]  status;

   assign sel = (ir_sel == IR_REG_ACCESS);

   tv_chain u_chain (
      .clk(clk), .rst_n(rst_n), .sel(sel), .cap_en(cap_en),
      .shift_en(shift_en), .upd_en(upd_en), .tdi(tdi), .hold(rd_hold),
      .tdo(tdo), .upd_fire(upd_fire), .upd_frame(upd_frame)
   );

   assign wr_hit      = upd_fire &&  upd_frame.write;
   assign rd_hit      = upd_fire && !upd_frame.write;
   assign ld_ctrl     = wr_hit && (upd_frame.addr == RA_CTRL);
   assign ld_tcount   = wr_hit && (upd_frame.addr == RA_TCOUNT);
   assign ld_wrptr    = wr_hit && (upd_frame.addr == RA_WRPTR);
   assign ld_rdptr    = wr_hit && (upd_frame.addr == RA_RDPTR);
   assign rd_data_hit = rd_hit && (upd_frame.addr == RA_DATA);

   tv_capture #(.AW(AW), .TCW(TCNT_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_trigger(trc_trigger),
      .ld_ctrl(ld_ctrl), .ld_tcount(ld_tcount), .ld_wrptr(ld_wrptr),
      .ld_data(upd_frame.data), .store(store), .wr_ptr(wr_ptr),
      .ctl_en(ctl_en), .active(active), .wrapped(wrapped),
      .triggered(triggered), .halted(halted), .tcount(tcount)
   );

   tv_ram #(.AW(AW), .WW(WORD_W)) u_ram (
      .clk(clk), .we(store), .waddr(wr_ptr), .wdata(trc_word),
      .raddr(rd_ptr), .rdata(ram_q)
   );

   if (WORD_W == REG_W) begin : g_full_word
      assign ram_ext = ram_q;
   end else begin : g_pad_word
      assign ram_ext = {{(REG_W-WORD_W){1'b0}}, ram_q};
   end

   assign status = {{(REG_W-4){1'b0}}, halted, triggered, wrapped, active};

   always_comb begin
      unique case (upd_frame.addr)
         RA_ID:     rd_value = ID_CODE;
         RA_DEPTH:  rd_value = REG_W'(DEPTH);
         RA_WIDTH:  rd_value = REG_W'(WORD_W);
         RA_STATUS: rd_value = status;
         RA_DATA:   rd_value = ram_ext;
         RA_RDPTR:  rd_value = REG_W'(rd_ptr);
         RA_WRPTR:  rd_value = REG_W'(wr_ptr);
         RA_TCOUNT: rd_value = REG_W'(tcount);
         RA_CTRL:   rd_value = {{(REG_W-1){1'b0}}, ctl_en};
         default:   rd_value = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hold <= '0;
         rd_ptr  <= '0;
      end else begin
         if (rd_hit)        rd_hold <= rd_value;
         if (ld_rdptr)      rd_ptr  <= upd_frame.data[AW-1:0];
         else if (rd_data_hit) rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/tv_checker.sv
module tv_checker #(
   parameter int AW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel,
   input logic          cap_en,
   input logic          hold_lsb,
   input logic          tdo,
   input logic          store,
   input logic [AW-1:0] wr_ptr,
   input logic          wrapped,
   input logic          ld_wrptr,
   input logic          halted,
   input logic          ctl_en,
   input logic          rd_data_hit,
   input logic          ld_rdptr,
   input logic [AW-1:0] rd_ptr
);
   assert_chain_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> $stable(tdo));

   assert_hold_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cap_en) |=> (tdo == $past(hold_lsb)));

   assert_data_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_hit && !ld_rdptr) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

   assert_wr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

   assert_wrap_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (store && (&wr_ptr)) |=> wrapped);

   assert_ptr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wrptr |=> !wrapped);

   assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_en && !ld_wrptr) |=> (wr_ptr == $past(wr_ptr)));

   assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !ld_wrptr) |=> (wr_ptr == $past(wr_ptr)));
endmodule

bind trace_vault tv_checker #(.AW(AW)) chk_i (
   .clk(clk), .rst_n(rst_n), .sel(sel), .cap_en(cap_en), .hold_lsb(rd_hold[0]),
   .tdo(tdo), .store(store), .wr_ptr(wr_ptr), .wrapped(wrapped),
   .ld_wrptr(ld_wrptr), .halted(halted), .ctl_en(ctl_en),
   .rd_data_hit(rd_data_hit), .ld_rdptr(ld_rdptr), .rd_ptr(rd_ptr)
);

// File: tb/trace_vault_tb.sv
`timescale 1ns/1ps
module trace_vault_tb_top;
   localparam int DL    = 6;
   localparam int DEPTH = 1 << DL;
   localparam int WW    = 20;
   localparam int TCW   = 16;
   localparam logic [31:0] ID = 32'h5A7C_0001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trc_valid = 1'b0;
   logic [WW-1:0] trc_word = '0;
   logic trc_trigger = 1'b0;
   logic [3:0] ir_sel = 4'hC;
   logic cap_en = 1'b0, shift_en = 1'b0, upd_en = 1'b0, tdi = 1'b0;
   logic tdo;

   always #2.5 clk = ~clk;

   trace_vault #(.DEPTH_LOG2(DL), .WORD_W(WW), .TCNT_W(TCW), .ID_CODE(ID)) dut_i (
      .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_word(trc_word),
      .trc_trigger(trc_trigger), .ir_sel(ir_sel), .cap_en(cap_en),
      .shift_en(shift_en), .upd_en(upd_en), .tdi(tdi), .tdo(tdo)
   );

   int n_chk = 0, n_fail = 0;
   logic [WW-1:0] m_ram [DEPTH];
   int m_wr = 0, m_rd = 0, m_tc = 0;
   bit m_en = 0, m_wrap = 0, m_trig = 0;

   function automatic bit m_halt();
      return m_trig && (m_tc == 0);
   endfunction
   function automatic logic [31:0] m_status();
      return {28'b0, m_halt(), m_trig, m_wrap, (m_en && !m_halt())};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic scan(input logic [39:0] fr, output logic [39:0] cap);
      @(negedge clk); cap_en = 1'b1;
      @(negedge clk); cap_en = 1'b0; shift_en = 1'b1;
      for (int i = 0; i < 40; i++) begin
         tdi = fr[i];
         cap[i] = tdo;
         @(negedge clk);
      end
      shift_en = 1'b0; upd_en = 1'b1;
      @(negedge clk); upd_en = 1'b0;
   endtask

   task automatic jw(input logic [6:0] a, input logic [31:0] d);
      logic [39:0] c;
      scan({1'b1, a, d}, c);
      if (ir_sel == 4'hC) begin
         case (a)
            7'd5: m_rd = int'(d) % DEPTH;
            7'd6: begin m_wr = int'(d) % DEPTH; m_wrap = 0; end
            7'd7: begin m_tc = int'(d[TCW-1:0]); m_trig = 0; end
            7'd8: m_en = d[0];
            default: ;
         endcase
      end
   endtask

   task automatic jsel(input logic [6:0] a, output logic [39:0] c);
      scan({1'b0, a, 32'h0}, c);
      if (a == 7'd4) m_rd = (m_rd + 1) % DEPTH;
   endtask

   task automatic jr(input logic [6:0] a, output logic [31:0] v);
      logic [39:0] c;
      jsel(a, c);
      jsel(7'd0, c);
      v = c[31:0];
   endtask

   task automatic push(input logic [WW-1:0] w, input bit trig, input bit valid);
      @(negedge clk);
      trc_valid = valid; trc_word = w; trc_trigger = trig;
      if (valid && m_en && !m_halt()) begin
         m_ram[m_wr] = w;
         if (m_wr == DEPTH-1) m_wrap = 1;
         m_wr = (m_wr + 1) % DEPTH;
         if (m_trig && m_tc != 0) m_tc--;
         if (trig && !m_trig) m_trig = 1;
      end
      @(negedge clk);
      trc_valid = 1'b0; trc_trigger = 1'b0;
   endtask

   task automatic burst(input int n);
      for (int i = 0; i < n; i++) push(WW'($urandom), 1'b0, 1'b1);
   endtask

   task automatic drain_check(input int start, input int cnt, input string tag);
      logic [39:0] c;
      jw(7'd5, 32'(start));
      jsel(7'd4, c);
      for (int i = 0; i < cnt; i++) begin
         if (i == cnt - 1) jsel(7'd0, c); else jsel(7'd4, c);
         check(tag, c[31:0], {12'b0, m_ram[(start + i) % DEPTH]});
      end
   endtask

   bit done = 0;

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [39:0] c;
      void'($urandom(32'h0000_2F1D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2: first capture after reset yields a zero hold value and zero upper bits
      jsel(7'd0, c);
      check("R2 reset hold", c[31:0], 32'h0);
      check("R2 upper bits", {24'b0, c[39:32]}, 32'h0);
      // R3: constants, pipelined by one scan
      jsel(7'd1, c); check("R3 id", c[31:0], ID);
      jsel(7'd2, c); check("R3 depth", c[31:0], 32'(DEPTH));
      jsel(7'd3, c); check("R3 width", c[31:0], 32'(WW));
      jsel(7'd0, c); check("R7 status reset", c[31:0], 32'h0);
      jw(7'd1, 32'h5); jr(7'd1, v); check("R3 depth ignores write", v, 32'(DEPTH));
      jr(7'd9, v);  check("R3 unmapped 9", v, 32'h0);
      jr(7'd127, v); check("R3 unmapped 127", v, 32'h0);

      // R7: enable then capture
      jw(7'd8, 32'h1);
      jr(7'd3, v); check("R7 status active", v, m_status());
      burst(10);
      jr(7'd6, v); check("R5 wr_ptr after 10", v, 32'(m_wr));
      drain_check(0, 10, "R4 sequential drain");
      jr(7'd5, v); check("R4 rd_ptr after drain", v, 32'(m_rd));

      // R4: selecting data twice in a row skips an entry
      jw(7'd5, 32'd3);
      jsel(7'd4, c);
      jsel(7'd4, c);
      jsel(7'd5, c); check("R4 second select returns entry 4", c[31:0], {12'b0, m_ram[4]});
      jsel(7'd0, c); check("R4 skip leaves pointer at 5", c[31:0], 32'd5);
      jw(7'd4, 32'hFFFF_FFFF);
      jr(7'd5, v); check("R4 write to data keeps pointer", v, 32'd5);

      // R1: other instruction codes leave everything alone
      ir_sel = 4'h2;
      jw(7'd5, 32'd20);
      ir_sel = 4'hC;
      jr(7'd5, v); check("R1 wrong instruction ignored", v, 32'd5);

      // R5: wrap
      burst(70);
      jr(7'd6, v); check("R5 wr_ptr wrapped", v, 32'(m_wr));
      jr(7'd3, v); check("R5 wrap flag", v, m_status());
      drain_check(m_wr, DEPTH, "R5 full drain from oldest");

      // random rounds with gaps
      for (int r = 0; r < 4; r++) begin
         int n;
         n = 20 + int'($urandom % 40);
         for (int i = 0; i < n; i++) push(WW'($urandom), 1'b0, ($urandom % 4) != 0);
         jr(7'd6, v); check("R5 random wr_ptr", v, 32'(m_wr));
         drain_check(int'($urandom % DEPTH), 8, "R4 random drain");
      end

      // R7: disabled capture stores nothing
      jw(7'd8, 32'h0);
      burst(5);
      jr(7'd6, v); check("R7 disabled wr_ptr", v, 32'(m_wr));
      jr(7'd3, v); check("R7 disabled status", v, m_status());

      // R8: trigger and countdown
      jw(7'd8, 32'h1);
      jw(7'd7, 32'd3);
      begin
         int base;
         base = m_wr;
         burst(2);
         push(WW'($urandom), 1'b1, 1'b1);
         burst(6);
         jr(7'd6, v); check("R8 stored trigger+3", v, 32'((base + 6) % DEPTH));
      end
      jr(7'd7, v); check("R8 count reached zero", v, 32'h0);
      jr(7'd3, v); check("R8 halted status", v, m_status());
      jw(7'd7, 32'd2);
      jr(7'd3, v); check("R8 rearm clears halt", v, m_status());
      push(WW'($urandom), 1'b1, 1'b1);
      push(WW'($urandom), 1'b0, 1'b1);
      jr(7'd7, v); check("R8 live count", v, 32'(m_tc));
      burst(4);
      jr(7'd6, v); check("R8 second window", v, 32'(m_wr));

      // R6: pointer load clears wrap
      jw(7'd6, 32'd5);
      jr(7'd6, v); check("R6 wr_ptr load", v, 32'd5);
      jr(7'd3, v); check("R6 wrap cleared", v, m_status());

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule